// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Controller

This block is a bus-slave peripheral that gives a processor one character terminal. The processor sees it as four word registers. On the input side, a keyboard-like source delivers bytes through a valid/data strobe. On the output side, a display-like sink takes bytes through a valid/ready handshake. Software can work in either of two ways. It can poll a ready flag in each control register before it touches the matching data register. Or it can set a per-side enable, so that a ready flag raises a level interrupt to the processor.

The ready flags move as a side effect of bus traffic. Reading the receive data register consumes the waiting character and drops receive-ready. Writing the transmit data register launches a character and drops transmit-ready until the sink takes it. A byte that arrives before the previous one was read replaces the previous one and leaves a sticky overrun mark. Reading the receive control register clears that mark.

The processor port is a single-cycle word access. Read data is combinational in the cycle where the select strobe is high. Side effects take place at the clock edge that ends that cycle.

Top module: `term_mmio`

## Requirements
- R1: After reset, the receive control word reads 0x0, the transmit control word reads 0x1, `irq` is 0 and `disp_valid` is 0.
- R2: Only the block base address is decoded, with `bus_addr[3:2]` as the word index: 0 receive control, 1 receive data, 2 transmit control, 3 transmit data. The default base is 0xFFFF0000. An access outside the 16-byte window reads 0x0 and changes no state. The transmit data register reads 0x0.
- R3: A `kb_valid` cycle stores `kb_data` and sets receive-ready (control bit 0). The receive data word returns the byte in bits 7:0 and zeros above it.
- R4: A read of the receive data register clears receive-ready from the next cycle, unless a byte arrives in that same cycle. A read of the receive control register leaves receive-ready unchanged.
- R5: A byte that arrives while receive-ready is 1, and while the data register is not being read, replaces the stored byte and sets overrun (receive control bit 2). A receive control read clears overrun. If a new overrun occurs in the same cycle as that read, the set wins.
- R6: A write to transmit data while transmit-ready is 1 drives `wdata[7:0]` on `disp_data` with `disp_valid` high from the next cycle. It also clears transmit-ready (transmit control bit 0). Byte and valid hold steady until `disp_ready` is seen.
- R7: A write to transmit data while transmit-ready is 0 is ignored. The byte on `disp_data` does not change.
- R8: A cycle with `disp_valid` and `disp_ready` both high ends the transfer. From the next cycle, transmit-ready is 1 and `disp_valid` is 0.
- R9: Bit 1 of each control register is a writable interrupt enable. Bit 0 (ready) ignores writes. The transmit control word reads zeros in bits 31:2, and the receive control word reads zeros in bits 31:3.
- R10: `irq` is a level equal to (receive enable AND receive-ready) OR (transmit enable AND transmit-ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| kb_valid | input | 1 | Incoming byte strobe |
| kb_data | input | 8 | Incoming byte |
| disp_valid | output | 1 | Outgoing byte valid |
| disp_data | output | 8 | Outgoing byte |
| disp_ready | input | 1 | Sink accepts the outgoing byte |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `kb_valid` is a one-cycle strobe per byte. They also assume that `disp_ready` is honoured only while `disp_valid` is high, and that the processor issues at most one access per cycle. The bench keeps within these limits. Each bus access is driven at the falling edge and lasts exactly one cycle. Each keyboard byte is a single-cycle strobe that never overlaps a bus read. The sink ready is raised for one cycle, and only after the outgoing byte has been checked.

// File: rtl/term_pkg.sv
package term_pkg;
  typedef enum logic [1:0] {
    IDX_RXCTL = 2'd0,
    IDX_RXDAT = 2'd1,
    IDX_TXCTL = 2'd2,
    IDX_TXDAT = 2'd3
  } reg_idx_t;

  localparam int BIT_RDY = 0;
  localparam int BIT_IE  = 1;
  localparam int BIT_OVR = 2;
endpackage

// File: rtl/term_rst_sync.sv
module term_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain[STAGES-1];
endmodule

// File: rtl/term_rx_chan.sv
module term_rx_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          ctl_wr,
  input  logic          ie_wdata,
  input  logic          ctl_rd,
  input  logic          dat_rd,
  output logic          ready,
  output logic          ie,
  output logic          ovr,
  output logic [DW-1:0] data
);
  logic ready_d, ie_d, ovr_d, ovr_hit;

  assign ovr_hit = in_valid && ready && !dat_rd;

  always_comb begin
    ready_d = ready;
    if (dat_rd)   ready_d = 1'b0;
    if (in_valid) ready_d = 1'b1;
    ovr_d = ovr;
    if (ctl_rd)   ovr_d = 1'b0;
    if (ovr_hit)  ovr_d = 1'b1;
    ie_d = ctl_wr ? ie_wdata : ie;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ready <= 1'b0;
      ie    <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      ready <= ready_d;
      ie    <= ie_d;
      ovr   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)        data <= '0;
    else if (in_valid) data <= in_data;
  end

  // R3: an arriving byte is held and flagged
  p_rx_arrive_r3: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> ready && (data == $past(in_data)));
  // R4: a data read with no arrival consumes the byte
  p_rx_consume_r4: assert property (@(posedge clk) disable iff (!rst_q)
    dat_rd && !in_valid |=> !ready);
  // R4: a control-only read keeps the flag
  p_rx_ctl_keep_r4: assert property (@(posedge clk) disable iff (!rst_q)
    ctl_rd && !dat_rd && !in_valid |=> ready == $past(ready));
  // R5: overrun is marked and survives a concurrent clear
  p_rx_overrun_r5: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid && ready && !dat_rd |=> ovr);
endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          wr_dat,
  input  logic [DW-1:0] wdata,
  input  logic          ctl_wr,
  input  logic          ie_wdata,
  input  logic          out_ready,
  output logic          ready,
  output logic          ie,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic accept, done, ready_d, ie_d;

  assign accept = wr_dat && ready;
  assign done   = !ready && out_ready;

  always_comb begin
    ready_d = ready;
    if (accept) ready_d = 1'b0;
    if (done)   ready_d = 1'b1;
    ie_d = ctl_wr ? ie_wdata : ie;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ready <= 1'b1;
      ie    <= 1'b0;
    end else begin
      ready <= ready_d;
      ie    <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      out_data <= '0;
    else if (accept) out_data <= wdata;
  end

  assign out_valid = !ready;

  // R6: an accepted write launches its byte
  p_tx_launch_r6: assert property (@(posedge clk) disable iff (!rst_q)
    wr_dat && ready |=> out_valid && (out_data == $past(wdata)));
  // R6 / R7: a pending byte is held until taken
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8: the handshake restores ready
  p_tx_done_r8: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && out_ready |=> ready && !out_valid);
endmodule

// File: rtl/term_mmio.sv
module term_mmio #(
  parameter int              AW        = 32,
  parameter int              XW        = 32,
  parameter int              DW        = 8,
  parameter logic [AW-1:0]   BASE_ADDR = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [XW-1:0] bus_wdata,
  output logic [XW-1:0] bus_rdata,
  input  logic          kb_valid,
  input  logic [DW-1:0] kb_data,
  output logic          disp_valid,
  output logic [DW-1:0] disp_data,
  input  logic          disp_ready,
  output logic          irq
);
  import term_pkg::*;

  localparam int CTLW = 3;

  logic           rst_q;
  logic           hit;
  reg_idx_t       idx;
  logic           rd, wr;
  logic           rx_ready, rx_ie, rx_ovr, tx_ready, tx_ie;
  logic [DW-1:0]  rx_data;
  logic           unused_bits;

  term_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  assign hit = (bus_addr[AW-1:4] == BASE_ADDR[AW-1:4]);
  assign idx = reg_idx_t'(bus_addr[3:2]);
  assign rd  = bus_sel && !bus_we && hit;
  assign wr  = bus_sel &&  bus_we && hit;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[XW-1:DW], BASE_ADDR[3:0]};

  term_rx_chan #(.DW(DW)) u_rx (
    .clk(clk), .rst_q(rst_q),
    .in_valid(kb_valid), .in_data(kb_data),
    .ctl_wr(wr && idx == IDX_RXCTL), .ie_wdata(bus_wdata[BIT_IE]),
    .ctl_rd(rd && idx == IDX_RXCTL), .dat_rd(rd && idx == IDX_RXDAT),
    .ready(rx_ready), .ie(rx_ie), .ovr(rx_ovr), .data(rx_data)
  );

  term_tx_chan #(.DW(DW)) u_tx (
    .clk(clk), .rst_q(rst_q),
    .wr_dat(wr && idx == IDX_TXDAT), .wdata(bus_wdata[DW-1:0]),
    .ctl_wr(wr && idx == IDX_TXCTL), .ie_wdata(bus_wdata[BIT_IE]),
    .out_ready(disp_ready),
    .ready(tx_ready), .ie(tx_ie), .out_valid(disp_valid), .out_data(disp_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we && hit) begin
      unique case (idx)
        IDX_RXCTL: bus_rdata = {{(XW-CTLW){1'b0}}, rx_ovr, rx_ie, rx_ready};
        IDX_RXDAT: bus_rdata = {{(XW-DW){1'b0}}, rx_data};
        IDX_TXCTL: bus_rdata = {{(XW-CTLW){1'b0}}, 1'b0, tx_ie, tx_ready};
        IDX_TXDAT: bus_rdata = '0;
      endcase
    end
  end

  assign irq = (rx_ie && rx_ready) || (tx_ie && tx_ready);

  // R10: no enable, no request
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !rx_ie && !tx_ie |-> !irq);
  // R2: a miss never returns data
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_q)
    bus_sel && !hit |-> bus_rdata == '0);
endmodule

// File: tb/term_mmio_test.sv
module term_mmio_test;
  localparam logic [31:0] A_RXC = 32'hFFFF_0000;
  localparam logic [31:0] A_RXD = 32'hFFFF_0004;
  localparam logic [31:0] A_TXC = 32'hFFFF_0008;
  localparam logic [31:0] A_TXD = 32'hFFFF_000C;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic kb_valid;
  logic [7:0] kb_data;
  logic disp_valid, disp_ready;
  logic [7:0] disp_data;
  logic irq;
  int checks = 0;
  int failures = 0;
  logic [31:0] d;

  always #10 clk = ~clk;

  term_mmio uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_data(kb_data), .disp_valid(disp_valid),
    .disp_data(disp_data), .disp_ready(disp_ready), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(posedge clk); #1 bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(posedge clk); #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic kb_push(input logic [7:0] b);
    @(negedge clk);
    kb_valid = 1'b1; kb_data = b;
    @(posedge clk); #1 kb_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd(A_RXC, d); check("R1 rx ctl", d, 32'h0);
    rd(A_TXC, d); check("R1 tx ctl", d, 32'h1);
    @(negedge clk);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 disp_valid", {31'b0, disp_valid}, 32'h0);
  endtask

  task automatic t_rx_basic;
    kb_push(8'hA5);
    rd(A_RXC, d); check("R3 ready set", d, 32'h1);
    rd(A_RXC, d); check("R4 ctl read keeps ready", d, 32'h1);
    rd(A_RXD, d); check("R3 data byte", d, 32'h0000_00A5);
    rd(A_RXC, d); check("R4 data read clears", d, 32'h0);
  endtask

  task automatic t_overrun;
    kb_push(8'h11);
    kb_push(8'h22);
    rd(A_RXC, d); check("R5 overrun set", d, 32'h5);
    rd(A_RXC, d); check("R5 overrun cleared", d, 32'h1);
    rd(A_RXD, d); check("R5 newer byte kept", d, 32'h22);
    rd(A_RXC, d); check("R4 cleared after overrun", d, 32'h0);
  endtask

  task automatic t_tx;
    disp_ready = 1'b0;
    wr(A_TXD, 32'hFFFF_FF3C);
    @(negedge clk);
    check("R6 disp_valid", {31'b0, disp_valid}, 32'h1);
    check("R6 disp_data", {24'b0, disp_data}, 32'h3C);
    rd(A_TXC, d); check("R6 tx ready cleared", d, 32'h0);
    wr(A_TXD, 32'h55);
    repeat (3) @(negedge clk);
    check("R7 busy write ignored", {24'b0, disp_data}, 32'h3C);
    check("R7 still valid", {31'b0, disp_valid}, 32'h1);
    @(negedge clk); disp_ready = 1'b1;
    @(posedge clk); #1 disp_ready = 1'b0;
    @(negedge clk);
    check("R8 valid dropped", {31'b0, disp_valid}, 32'h0);
    rd(A_TXC, d); check("R8 tx ready back", d, 32'h1);
  endtask

  task automatic t_ie;
    wr(A_RXC, 32'hFFFF_FFFE);
    rd(A_RXC, d); check("R9 ie set ready ignored", d, 32'h2);
    @(negedge clk); check("R10 irq idle", {31'b0, irq}, 32'h0);
    kb_push(8'h7E);
    @(negedge clk); check("R10 irq rx", {31'b0, irq}, 32'h1);
    rd(A_RXD, d);
    @(negedge clk); check("R10 irq rx cleared", {31'b0, irq}, 32'h0);
    wr(A_RXC, 32'h0);
    wr(A_TXC, 32'h3);
    rd(A_TXC, d); check("R9 tx ctl bits", d, 32'h3);
    @(negedge clk); check("R10 irq tx", {31'b0, irq}, 32'h1);
    wr(A_TXC, 32'h0);
    @(negedge clk); check("R10 irq off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_decode;
    wr(32'h0000_0008, 32'h2);
    rd(A_TXC, d); check("R2 miss write ignored", d, 32'h1);
    kb_push(8'h99);
    rd(32'hFFFF_0010, d); check("R2 miss reads zero", d, 32'h0);
    rd(32'h0000_0004, d); check("R2 alias read zero", d, 32'h0);
    rd(A_RXC, d); check("R2 miss read kept ready", d, 32'h1);
    rd(A_TXD, d); check("R2 tx data reads zero", d, 32'h0);
    rd(A_RXD, d); check("R2 rx data", d, 32'h99);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    kb_valid = 1'b0; kb_data = '0; disp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_rx_basic;
    t_overrun;
    t_tx;
    t_ie;
    t_decode;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule